// File: doc/BRIEF.md
# Delay-Line Length Calibration Sequencer

This block finds the coarse step size for a tapped delay line that shifts a sampling clock. A start pulse begins a sweep of the 7-bit unit-delay setting. The sweep counts up from 0. For each setting the sequencer writes a configuration to the line. That configuration holds the delay enable, the sampler enable and a tap select of 12, which is one more than the 11 taps. The sequencer then waits for the line to raise its length-valid flag and judges the 12-bit length word the line returns.

The first setting whose length word is nonzero and below 2048 ends the sweep. That means one clock period fits inside the taps. The sequencer reports that unit value and the index of the highest set bit of the length word, which is the highest tap index that can be used. A setting whose flag does not appear within the timeout window is skipped. If all 128 settings pass without success, the run ends with a failure indication. The timeout window is given in microseconds and converted to cycles with a cycles-per-microsecond parameter.

Top module: `dlcal_ctrl`

## Requirements
- R1: While reset is held and directly after it: busy, done, fail, dl_cfg_wr, dl_en and dl_sample_en are 0; unit_out, max_tap and dl_sel are 0.
- R2: A start pulse while idle begins a sweep. The first configuration write carries unit 0, and each later write carries the previous unit plus one.
- R3: Every configuration write presents dl_sel = 12. dl_en and dl_sample_en are 1 for the whole run and 0 whenever busy is 0.
- R4: After a write, len_word is sampled only in a cycle where len_valid is 1. A length word presented while len_valid is 0 has no effect on the result.
- R5: A length word L is accepted when 0 < L < 2048. L = 0 or L >= 2048 is rejected and the sweep moves to the next unit. An accepted L ends the run with unit_out set to the unit in use.
- R6: On acceptance, max_tap equals the bit position (0 to 10) of the most significant 1 in L.
- R7: If len_valid does not arrive within TIMEOUT_US * CYC_PER_US cycles after a write, the unit is skipped. The next write comes exactly TIMEOUT_US * CYC_PER_US + 1 cycles after the previous one.
- R8: When unit 127 is left without acceptance, the run ends with fail = 1, after 128 writes. unit_out and max_tap keep their earlier values. fail returns to 0 when the next run is started.
- R9: done is a single-cycle pulse. busy is 0 in that cycle, and fail, unit_out and max_tap are valid in it. They hold their values until the next start.
- R10: A start pulse while busy is ignored. The unit sequence continues without restarting and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (honoured only when idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Last run found no usable unit setting |
| unit_out | output | 7 | Chosen unit-delay setting |
| max_tap | output | 4 | Highest usable tap index |
| dl_cfg_wr | output | 1 | Configuration write strobe to the delay line |
| dl_en | output | 1 | Delay enable toward the line |
| dl_sample_en | output | 1 | Sampler enable toward the line |
| dl_unit | output | 7 | Unit-delay setting being programmed |
| dl_sel | output | 4 | Tap select (12 during calibration) |
| len_valid | input | 1 | Line length measurement is valid |
| len_word | input | 12 | Captured line length |

## Verification
The bench walks the length boundaries 0, 1, 2047, 2048 and 4095 and the unit extremes 0 and 127.

- A design with an off-by-one in the range test would accept 2048 or reject 2047. A wrong highest-bit search would report the wrong tap.
- While len_valid is 0, the bench model drives an acceptable length word. A design that reads the length without its flag would then stop too early.
- For units that never answer, the spacing between writes is measured. A timeout counter that is one cycle short or long shows up there.
- An all-silent sweep and an all-rejected sweep check that unit 127 is still tried and that the previous result is kept.
- A start injected mid-run would restart the unit sequence at 0 if the design did not ignore it.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;
  localparam int UNIT_W  = 7;
  localparam int NB_TAPS = 11;
  localparam int SEL_W   = 4;
  localparam int LEN_W   = NB_TAPS + 1;
  localparam int TAP_W   = $clog2(NB_TAPS);
  localparam logic [SEL_W-1:0] SEL_CAL = SEL_W'(NB_TAPS + 1);
  localparam logic [UNIT_W-1:0] UNIT_LAST = {UNIT_W{1'b1}};

  typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_WAIT} dlcal_state_e;

  // length fits: nonzero and shorter than the tap chain span
  function automatic logic len_usable(input logic [LEN_W-1:0] v);
    return (v != '0) && (v < LEN_W'(1 << NB_TAPS));
  endfunction

  // index of the most significant set bit
  function automatic logic [TAP_W-1:0] msb_pos(input logic [LEN_W-1:0] v);
    logic [TAP_W-1:0] p;
    p = '0;
    for (int i = 0; i < LEN_W; i++)
      if (v[i]) p = TAP_W'(i);
    return p;
  endfunction
endpackage

// File: rtl/dlcal_timer.sv
module dlcal_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt_q;

  assign expire = run && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (run && !expire) cnt_q <= cnt_q + 1'b1;
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < CNT_W'(LIMIT)));
endmodule

// File: rtl/dlcal_judge.sv
module dlcal_judge
  import dlcal_pkg::*;
(
  input  logic [LEN_W-1:0] len_word,
  output logic             ok,
  output logic [TAP_W-1:0] tap
);
  assign ok  = len_usable(len_word);
  assign tap = msb_pos(len_word);
endmodule

// File: rtl/dlcal_seq.sv
module dlcal_seq
  import dlcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              len_valid,
  input  logic              len_ok,
  input  logic [TAP_W-1:0]  len_tap,
  input  logic              tmo,
  output logic              tmr_clr,
  output logic              tmr_run,
  output logic              busy,
  output logic              cfg_wr,
  output logic [UNIT_W-1:0] unit_cnt,
  output logic              done,
  output logic              fail,
  output logic [UNIT_W-1:0] unit_out,
  output logic [TAP_W-1:0]  max_tap
);
  dlcal_state_e state_q;
  logic accept_ev, reject_ev, skip_ev, exhaust_ev, start_ev;

  assign busy       = (state_q != ST_IDLE);
  assign cfg_wr     = (state_q == ST_PROG);
  assign tmr_clr    = cfg_wr;
  assign tmr_run    = (state_q == ST_WAIT);
  assign start_ev   = (state_q == ST_IDLE) && start;
  assign accept_ev  = tmr_run && len_valid && len_ok;
  assign reject_ev  = tmr_run && ((len_valid && !len_ok) || (!len_valid && tmo));
  assign exhaust_ev = reject_ev && (unit_cnt == UNIT_LAST);
  assign skip_ev    = reject_ev && (unit_cnt != UNIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      unit_cnt <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
      unit_out <= '0;
      max_tap  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_ev) begin
          unit_cnt <= '0;
          fail     <= 1'b0;
          state_q  <= ST_PROG;
        end
        ST_PROG: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (accept_ev) begin
            unit_out <= unit_cnt;
            max_tap  <= len_tap;
            done     <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (exhaust_ev) begin
            fail    <= 1'b1;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (skip_ev) begin
            unit_cnt <= unit_cnt + 1'b1;
            state_q  <= ST_PROG;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (done && !fail && !busy));
  // R7
  skip_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_run && tmo && !len_valid && unit_cnt != UNIT_LAST) |=> cfg_wr);
  // R8
  exhaust_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust_ev |=> (done && fail && $stable(unit_out) && $stable(max_tap)));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && start) |=> (busy && $stable(unit_cnt)));
endmodule

// File: rtl/dlcal_ctrl.sv
module dlcal_ctrl
  import dlcal_pkg::*;
#(
  parameter int CYC_PER_US = 125,
  parameter int TIMEOUT_US = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [UNIT_W-1:0] unit_out,
  output logic [TAP_W-1:0]  max_tap,
  output logic              dl_cfg_wr,
  output logic              dl_en,
  output logic              dl_sample_en,
  output logic [UNIT_W-1:0] dl_unit,
  output logic [SEL_W-1:0]  dl_sel,
  input  logic              len_valid,
  input  logic [LEN_W-1:0]  len_word
);
  localparam int TMO_CYC = CYC_PER_US * TIMEOUT_US;

  logic             len_ok, tmo, tmr_clr, tmr_run;
  logic [TAP_W-1:0] len_tap;

  dlcal_judge u_judge (
    .len_word (len_word),
    .ok       (len_ok),
    .tap      (len_tap)
  );

  dlcal_timer #(.LIMIT(TMO_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tmr_clr),
    .run    (tmr_run),
    .expire (tmo)
  );

  dlcal_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .len_valid (len_valid),
    .len_ok    (len_ok),
    .len_tap   (len_tap),
    .tmo       (tmo),
    .tmr_clr   (tmr_clr),
    .tmr_run   (tmr_run),
    .busy      (busy),
    .cfg_wr    (dl_cfg_wr),
    .unit_cnt  (dl_unit),
    .done      (done),
    .fail      (fail),
    .unit_out  (unit_out),
    .max_tap   (max_tap)
  );

  assign dl_en        = busy;
  assign dl_sample_en = busy;
  assign dl_sel       = busy ? SEL_CAL : '0;

  // R6
  tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> (max_tap < TAP_W'(NB_TAPS)));
  // R3
  cfg_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_cfg_wr |-> (dl_sel == SEL_CAL && dl_en && dl_sample_en));
endmodule

// File: tb/sim_dlcal_ctrl.sv
module sim_dlcal_ctrl;
  localparam int CPU = 2;
  localparam int TUS = 5;
  localparam int TMO = CPU * TUS;
  localparam int NV  = 8;
  // fields: silent_below[39:32], good_unit[31:24], good_len[23:12], other_len[11:0]
  localparam logic [39:0] VEC [NV] = '{
    {8'd0,   8'd0,   12'h001, 12'h000},
    {8'd0,   8'd5,   12'h400, 12'h000},
    {8'd0,   8'd3,   12'h7FF, 12'h800},
    {8'd0,   8'd9,   12'h0A5, 12'hFFF},
    {8'd3,   8'd4,   12'h006, 12'h000},
    {8'd0,   8'd128, 12'h000, 12'h000},
    {8'd128, 8'd128, 12'h000, 12'h000},
    {8'd0,   8'd127, 12'h002, 12'h000}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, fail, dl_cfg_wr, dl_en, dl_sample_en, len_valid;
  logic [6:0] unit_out, dl_unit;
  logic [3:0] max_tap, dl_sel;
  logic [11:0] len_word;

  always #4 clk = ~clk;

  dlcal_ctrl #(.CYC_PER_US(CPU), .TIMEOUT_US(TUS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .unit_out(unit_out), .max_tap(max_tap),
    .dl_cfg_wr(dl_cfg_wr), .dl_en(dl_en), .dl_sample_en(dl_sample_en),
    .dl_unit(dl_unit), .dl_sel(dl_sel), .len_valid(len_valid), .len_word(len_word));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int silent = 0, good_u = 128, nwr = 0, last_cyc = 0, prev_u = 0, lat = 0, cur_u = 0;
  logic [11:0] good_l = 0, other_l = 0;
  bit first = 1, pend = 0, e_cfg = 0, e_seq = 0, e_tmo = 0, e_idle = 0;
  int exp_u = 0, exp_t = 0;
  bit exp_f = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // delay-line model and monitor
  always @(negedge clk) begin
    cyc++;
    if (!busy && (dl_en || dl_sample_en)) e_idle = 1;
    if (dl_cfg_wr) begin
      nwr++;
      if (dl_sel != 4'd12 || !dl_en || !dl_sample_en) e_cfg = 1;
      if (first) begin
        if (dl_unit != 0) e_seq = 1;
      end else begin
        if (int'(dl_unit) != prev_u + 1) e_seq = 1;
        if (prev_u < silent && (cyc - last_cyc) != TMO + 1) e_tmo = 1;
      end
      first = 0;
      prev_u = dl_unit;
      last_cyc = cyc;
      cur_u = dl_unit;
      lat = 0;
      pend = 1;
      len_valid = 0;
      len_word = 12'h004;
    end else if (pend) begin
      lat++;
      if (lat == 2) begin
        pend = 0;
        if (cur_u >= silent) begin
          len_valid = 1;
          len_word = (cur_u == good_u) ? good_l : other_l;
        end
      end
    end
  end

  function automatic int ref_top(input logic [11:0] v);
    int t = -1;
    logic [11:0] w = v;
    while (w != 0) begin w = w >> 1; t++; end
    return t;
  endfunction

  task automatic run(input int idx, input bit inject);
    logic [39:0] v = VEC[idx];
    int waited = 0;
    bit found = 0;
    int tries = 0;
    silent = v[39:32]; good_u = v[31:24]; good_l = v[23:12]; other_l = v[11:0];
    for (int u = 0; u < 128 && !found; u++) begin
      logic [11:0] l;
      tries++;
      if (u < silent) continue;
      l = (u == good_u) ? good_l : other_l;
      if (l != 0 && l < 12'd2048) begin
        found = 1; exp_u = u; exp_t = ref_top(l);
      end
    end
    exp_f = !found;
    first = 1; nwr = 0; e_cfg = 0; e_seq = 0; e_tmo = 0; e_idle = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (inject) begin
      repeat (20) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
    end
    while (!done && waited < 5000) begin @(negedge clk); waited++; end
    chk(done, "R9 done seen", done, 1);
    chk(fail == exp_f, exp_f ? "R8 fail flag" : "R5 fail flag", fail, exp_f);
    chk(unit_out == exp_u, exp_f ? "R8 unit held" : "R5 unit", unit_out, exp_u);
    chk(max_tap == exp_t, exp_f ? "R8 tap held" : "R6 tap", max_tap, exp_t);
    chk(nwr == tries, exp_f ? "R8 write count" : "R4 write count", nwr, tries);
    chk(!busy, "R9 busy at done", busy, 0);
    chk(!e_cfg, "R3 sel/enables on write", e_cfg, 0);
    chk(!e_seq, inject ? "R10 unit sequence" : "R2 unit sequence", e_seq, 0);
    if (silent > 0) chk(!e_tmo, "R7 timeout spacing", e_tmo, 0);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(unit_out == exp_u && max_tap == exp_t && fail == exp_f, "R9 hold",
        unit_out, exp_u);
    chk(!e_idle, "R3 enables low when idle", e_idle, 0);
  endtask

  initial begin
    len_valid = 0; len_word = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !done && !fail && !dl_cfg_wr && !dl_en && !dl_sample_en,
        "R1 flags in reset", {busy, done, fail, dl_cfg_wr, dl_en}, 0);
    chk(unit_out == 0 && max_tap == 0 && dl_sel == 0, "R1 values in reset",
        unit_out, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && unit_out == 0, "R1 after reset", busy, 0);
    for (int i = 0; i < NV; i++) run(i, 0);
    // R10: start injected mid-run during silent units
    run(4, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule